// File: doc/BRIEF.md
# Dual-Channel Register Access Steering

This block sits between a host bus and the two register files of a two-channel serial controller. It decodes an active-low chip select and a channel-select line. Each host access then reaches channel A, channel B, or neither. The two channels lay out their registers at identical addresses, so the block passes one address and one data word to both files. Only the per-channel write enables and read selects tell the files apart.

A shared broadcast flag is bit 0 of an alternate-function register at a fixed address. When the flag is set, a write cycle ignores channel-select and loads the same register in both channels in a single cycle. This lets software set up both channels together. Reads are never broadcast. Read data always comes back from the one channel that channel-select names.

Write enables are registered, one-cycle pulses. The address and data that go with them are held in flops next to the pulse. Read selects and the read-data multiplexer are combinational, so a register file can return its data within the same bus cycle.

Top module: `chan_access_steer`

## Requirements
- R1: While rst_ni is low and right after it rises, we_a_o, we_b_o and bcast_o are 0.
- R2: While cs_ni is 1, no write enable pulses and neither read select is asserted, whatever chsel_i, rd_i, wr_i and the broadcast flag are; rdata_o is then 0.
- R3: With cs_ni=0, chsel_i=1 and the broadcast flag 0, a write produces we_a_o=1 and we_b_o=0 for exactly the cycle after the sampling clock edge, with addr_o and wdata_o equal to the sampled address and data.
- R4: With cs_ni=0, chsel_i=0 and the broadcast flag 0, a write produces we_b_o=1 and we_a_o=0 in the cycle after the sampling edge, with addr_o and wdata_o carrying the write.
- R5: With the broadcast flag 1 and cs_ni=0, a write asserts we_a_o and we_b_o together in the same cycle for either value of chsel_i.
- R6: A read with cs_ni=0 asserts re_a_o alone when chsel_i=1 and re_b_o alone when chsel_i=0, with rdata_o equal to that channel's read data in the same cycle; this holds even with the broadcast flag 1.
- R7: The broadcast flag takes wdata_i bit 0 on a write to address ALT_ADDR (default 4'hA) through either channel. It is visible on bcast_o from the cycle after the write. It governs writes sampled after that one, not the write that changes it. Writes to other addresses leave it unchanged.
- R8: A write strobe held high for several cycles gives a single enable pulse; a new pulse needs wr_i (or chip select) to drop first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| chsel_i | input | 1 | Channel select: 1 = channel A, 0 = channel B |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_a_i | input | DATA_W | Read data from channel A register file |
| rdata_b_i | input | DATA_W | Read data from channel B register file |
| we_a_o | output | 1 | Channel A write enable pulse |
| we_b_o | output | 1 | Channel B write enable pulse |
| addr_o | output | ADDR_W | Registered address shared by both channels |
| wdata_o | output | DATA_W | Registered write data shared by both channels |
| re_a_o | output | 1 | Channel A read select |
| re_b_o | output | 1 | Channel B read select |
| rdata_o | output | DATA_W | Steered read data to host |
| bcast_o | output | 1 | Current broadcast flag |

## Verification
The assertions assume that the strobes and chip select are settled at each rising edge and carry no X after reset. They also assume that a read and a write are not both presented to the host side on purpose. The bench drives every input on the falling edge and holds it through the next rising edge. It keeps rd_i and wr_i mutually exclusive and releases the strobe and chip select after every access, so each write is seen as a fresh strobe.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int NCH = 2;
  localparam int CH_A = 0;
  localparam int CH_B = 1;
  typedef logic [NCH-1:0] ch_vec_t;
endpackage

// File: rtl/steer_decode.sv
module steer_decode
  import steer_pkg::*;
(
  input  logic    cs_ni,
  input  logic    chsel_i,
  input  logic    bcast_i,
  input  logic    wr_fire_i,
  input  logic    rd_i,
  output ch_vec_t wr_hit_o,
  output ch_vec_t rd_hit_o
);
  ch_vec_t sel_vec;

  always_comb begin
    sel_vec = '0;
    if (!cs_ni) begin
      if (chsel_i) sel_vec[CH_A] = 1'b1;
      else         sel_vec[CH_B] = 1'b1;
    end
  end

  // broadcast only widens writes; wr_fire already carries chip select
  always_comb begin
    wr_hit_o = '0;
    if (wr_fire_i) wr_hit_o = bcast_i ? {NCH{1'b1}} : sel_vec;
  end

  assign rd_hit_o = rd_i ? sel_vec : '0;

  always_comb begin
    AST_RD_SINGLE: assert ($onehot0(rd_hit_o)); // R6
  end
endmodule

// File: rtl/steer_bcast_reg.sv
module steer_bcast_reg #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] ALT_ADDR = 4'hA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wbit_i,
  output logic              bcast_o
);
  logic upd;
  assign upd = wr_fire_i && (addr_i == ALT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  bcast_o <= 1'b0;
    else if (upd) bcast_o <= wbit_i;
  end

  AST_BCAST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_fire_i && addr_i == ALT_ADDR) |=> $stable(bcast_o)); // R7
endmodule

// File: rtl/steer_wr_stage.sv
module steer_wr_stage
  import steer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  ch_vec_t           wr_hit_i,
  output logic              wr_fire_o,
  output ch_vec_t           we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic wr_qual, wr_prev_q;

  assign wr_qual   = !cs_ni && wr_i;
  assign wr_fire_o = wr_qual && !wr_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_prev_q <= 1'b0;
    else         wr_prev_q <= wr_qual;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (wr_fire_o) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_we
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) we_o[g] <= 1'b0;
      else         we_o[g] <= wr_hit_i[g];
    end

    AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_o[g] |=> !we_o[g]); // R8
  end

  AST_WE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we_o) |-> $past(!cs_ni && wr_i)); // R2
endmodule

// File: rtl/steer_rd_mux.sv
module steer_rd_mux
  import steer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  ch_vec_t           rd_hit_i,
  input  logic [DATA_W-1:0] rdata_a_i,
  input  logic [DATA_W-1:0] rdata_b_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] src [NCH];
  assign src[CH_A] = rdata_a_i;
  assign src[CH_B] = rdata_b_i;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++)
      if (rd_hit_i[i]) rdata_o = rdata_o | src[i];
  end
endmodule

// File: rtl/chan_access_steer.sv
module chan_access_steer
  import steer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ALT_ADDR = 4'hA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              chsel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_a_i,
  input  logic [DATA_W-1:0] rdata_b_i,
  output logic              we_a_o,
  output logic              we_b_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              re_a_o,
  output logic              re_b_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bcast_o
);
  logic    wr_fire;
  ch_vec_t wr_hit, rd_hit, we;

  steer_decode i_decode (
    .cs_ni     (cs_ni),
    .chsel_i   (chsel_i),
    .bcast_i   (bcast_o),
    .wr_fire_i (wr_fire),
    .rd_i      (rd_i),
    .wr_hit_o  (wr_hit),
    .rd_hit_o  (rd_hit)
  );

  steer_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wr_hit_i  (wr_hit),
    .wr_fire_o (wr_fire),
    .we_o      (we),
    .addr_o    (addr_o),
    .wdata_o   (wdata_o)
  );

  steer_bcast_reg #(.ADDR_W(ADDR_W), .ALT_ADDR(ALT_ADDR)) i_bcast (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_fire_i (wr_fire),
    .addr_i    (addr_i),
    .wbit_i    (wdata_i[0]),
    .bcast_o   (bcast_o)
  );

  steer_rd_mux #(.DATA_W(DATA_W)) i_rd_mux (
    .rd_hit_i  (rd_hit),
    .rdata_a_i (rdata_a_i),
    .rdata_b_i (rdata_b_i),
    .rdata_o   (rdata_o)
  );

  assign we_a_o = we[CH_A];
  assign we_b_o = we[CH_B];
  assign re_a_o = rd_hit[CH_A];
  assign re_b_o = rd_hit[CH_B];

  AST_BOTH_NEEDS_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_a_o && we_b_o) |-> $past(bcast_o)); // R5
  AST_CS_IDLE_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!re_a_o && !re_b_o && rdata_o == '0)); // R2
  AST_A_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_a_o && !we_b_o) |-> $past(chsel_i)); // R3
  AST_B_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_b_o && !we_a_o) |-> $past(!chsel_i)); // R4
endmodule

// File: tb/test_chan_access_steer.sv
module test_chan_access_steer;
  localparam logic [3:0] ALT = 4'hA;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, chsel_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_a_i = 8'hA5, rdata_b_i = 8'h5A;
  logic       we_a_o, we_b_o, re_a_o, re_b_o, bcast_o;
  logic [3:0] addr_o;
  logic [7:0] wdata_o, rdata_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  chan_access_steer i_chan_access_steer (
    .clk_i, .rst_ni, .cs_ni, .chsel_i, .rd_i, .wr_i, .addr_i, .wdata_i,
    .rdata_a_i, .rdata_b_i, .we_a_o, .we_b_o, .addr_o, .wdata_o,
    .re_a_o, .re_b_o, .rdata_o, .bcast_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(we_a_o == 0 && we_b_o == 0, "R1 we in reset", {we_a_o, we_b_o}, 0);
    chk(bcast_o == 0, "R1 bcast in reset", bcast_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(we_a_o == 0 && we_b_o == 0 && bcast_o == 0, "R1 after reset",
        {we_a_o, we_b_o, bcast_o}, 0);
  endtask

  // write cycle; ea/eb are the expected enables in the following cycle
  task automatic t_write(input logic cs_n, input logic sel, input logic [3:0] a,
                         input logic [7:0] d, input logic ea, input logic eb,
                         input string tag);
    @(negedge clk_i);
    cs_ni = cs_n; chsel_i = sel; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    chk(we_a_o == ea && we_b_o == eb, {tag, " enables"}, {we_a_o, we_b_o}, {ea, eb});
    if (ea || eb)
      chk(addr_o == a && wdata_o == d, {tag, " addr/data"}, {addr_o, wdata_o}, {a, d});
    wr_i = 1'b0; cs_ni = 1'b1;
    @(negedge clk_i);
    chk(we_a_o == 0 && we_b_o == 0, {tag, " pulse ends"}, {we_a_o, we_b_o}, 0);
  endtask

  task automatic t_read(input logic cs_n, input logic sel, input logic ea,
                        input logic eb, input logic [7:0] ed, input string tag);
    @(negedge clk_i);
    cs_ni = cs_n; chsel_i = sel; rd_i = 1'b1;
    #2;
    chk(re_a_o == ea && re_b_o == eb, {tag, " selects"}, {re_a_o, re_b_o}, {ea, eb});
    chk(rdata_o == ed, {tag, " data"}, rdata_o, ed);
    @(negedge clk_i);
    chk(we_a_o == 0 && we_b_o == 0, {tag, " no write"}, {we_a_o, we_b_o}, 0);
    rd_i = 1'b0; cs_ni = 1'b1;
  endtask

  task automatic t_held_strobe();
    @(negedge clk_i);
    cs_ni = 1'b0; chsel_i = 1'b1; wr_i = 1'b1; addr_i = 4'h3; wdata_i = 8'h77;
    @(negedge clk_i);
    chk(we_a_o == 1, "R8 first pulse", we_a_o, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(we_a_o == 0 && we_b_o == 0, "R8 held strobe quiet", {we_a_o, we_b_o}, 0);
    end
    wr_i = 1'b0;
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = 8'h78;
    @(negedge clk_i);
    chk(we_a_o == 1 && wdata_o == 8'h78, "R8 re-armed pulse", {we_a_o, wdata_o}, {1'b1, 8'h78});
    wr_i = 1'b0; cs_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_bcast();
    // set flag through channel B: this write itself is not broadcast
    t_write(1'b0, 1'b0, ALT, 8'h01, 1'b0, 1'b1, "R7 set via B");
    chk(bcast_o == 1, "R7 flag set", bcast_o, 1);
    t_write(1'b0, 1'b1, 4'h2, 8'h3C, 1'b1, 1'b1, "R5 bcast sel A");
    t_write(1'b0, 1'b0, 4'h5, 8'hC3, 1'b1, 1'b1, "R5 bcast sel B");
    t_write(1'b1, 1'b1, 4'h5, 8'h11, 1'b0, 1'b0, "R2 cs high bcast");
    t_read(1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, "R6 read A bcast");
    t_read(1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, "R6 read B bcast");
    // clearing write via channel A is still broadcast
    t_write(1'b0, 1'b1, ALT, 8'h00, 1'b1, 1'b1, "R7 clear via A");
    chk(bcast_o == 0, "R7 flag cleared", bcast_o, 0);
    t_write(1'b0, 1'b1, 4'h4, 8'hFF, 1'b1, 1'b0, "R7 other addr");
    chk(bcast_o == 0, "R7 other addr keeps flag", bcast_o, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #3;
    t_reset();
    t_write(1'b0, 1'b1, 4'h1, 8'h12, 1'b1, 1'b0, "R3 write A");
    t_write(1'b0, 1'b0, 4'h6, 8'h9E, 1'b0, 1'b1, "R4 write B");
    t_write(1'b1, 1'b1, 4'h1, 8'h55, 1'b0, 1'b0, "R2 cs high sel A");
    t_write(1'b1, 1'b0, ALT, 8'h01, 1'b0, 1'b0, "R2 cs high alt");
    chk(bcast_o == 0, "R2 deselected alt write ignored", bcast_o, 0);
    t_read(1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, "R6 read A");
    t_read(1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, "R6 read B");
    t_read(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R2 read cs high A");
    t_read(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R2 read cs high B");
    t_held_strobe();
    t_bcast();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule